// File: doc/BRIEF.md
# Vector Bytecode Instruction Decoder

This block sits in front of a bytecode execution pipeline and turns a raw byte stream into decoded vector-instruction records. Bytes arrive one per cycle over a valid/ready handshake. A byte equal to the vector prefix (0xFD) opens an instruction. The opcode that follows is a variable-length unsigned integer of at most 32 bits in LEB128 form. The opcode then selects what comes after it: nothing, a memory argument made of two LEB128 fields, sixteen raw bytes, or a single lane-index byte.

When an instruction is complete, the decoder presents one record on its output handshake. The record holds the opcode number, the immediate class, the immediate values and an error code. Any byte seen outside an instruction that is not the prefix is forwarded as a plain record marked "not vector". While a record waits for the consumer, the input is stalled. Malformed LEB128 fields and opcodes outside the defined set are reported in the record, and decoding restarts cleanly with the next byte.

Top module: `simd_stream_decoder`

## Requirements
- R1: A byte other than 0xFD received while idle yields a record with out_is_vec=0, out_opcode equal to that byte, out_kind=0 and out_err=0.
- R2: The opcode after 0xFD is decoded as LEB128: each byte contributes bits 6:0 at position 7·n, and a byte with bit 7 clear is the last one. Multi-byte and padded five-byte encodings give the same value as the short form.
- R3: Opcodes 0 to 11 are followed by two LEB128 fields, the alignment exponent and then the byte offset. Their record has out_kind=1 and carries both values on out_align and out_offset.
- R4: Opcode 12 is followed by 16 bytes that are assembled little-endian into out_imm: byte k lands in bits 8k+7:8k. The record has out_kind=2.
- R5: Opcode 13 is followed by 16 lane-index bytes. Lane k is reported unchanged in out_imm bits 8k+7:8k, and the record has out_kind=2.
- R6: Opcodes 21 to 34 are followed by exactly one byte, which is reported on out_lane with out_kind=3.
- R7: The other defined opcodes take no immediates. These are 14–20, 35–82, and the defined codes of the 96–251 range (for example 96, 224 and 251). Their record has out_kind=0 and is presented right after the last opcode byte.
- R8: A LEB128 field whose fifth byte has bit 7 set, or has any of bits 6:4 set, produces a record with out_err=1. The next byte is then decoded from the idle state.
- R9: An opcode outside the defined set (for example 83 or 195) produces a record with out_err=2, out_kind=0 and all immediate outputs zero. The next byte is then decoded from the idle state.
- R10: While out_valid=1 and out_ready=0, out_valid stays high, every record field holds its value, and in_ready is low.
- R11: A synchronous reset clears out_valid, drops any partly collected instruction and returns the decoder to the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Input stream byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_valid | output | 1 | Record is valid |
| out_ready | input | 1 | Consumer takes the record |
| out_is_vec | output | 1 | 1 = vector instruction, 0 = forwarded plain byte |
| out_opcode | output | 32 | Decoded opcode, or the plain byte |
| out_kind | output | 2 | Immediate class: 0 none, 1 memory argument, 2 sixteen bytes, 3 lane byte |
| out_err | output | 2 | 0 none, 1 malformed LEB128, 2 unknown opcode |
| out_align | output | 32 | Alignment exponent of the memory argument |
| out_offset | output | 32 | Byte offset of the memory argument |
| out_lane | output | 8 | Lane-index immediate |
| out_imm | output | 128 | Sixteen-byte immediate, byte k at bits 8k+7:8k |

## Verification
The assertions check several properties on every cycle. They confirm that a stalled record stays stable and valid, and that plain-byte and unknown-opcode records carry no class, error or immediate. They also confirm that memory-argument and lane records only ever carry opcodes from their ranges, and that the LEB128 byte counter advances one step per continuation byte. The bench scenarios cover the rest. These are the exact values assembled from multi-byte fields, little-endian byte placement, the five-byte LEB128 boundary with its error forms, resynchronisation after an error, and the loss of a half-received instruction at reset.

// File: rtl/simd_dec_pkg.sv
package simd_dec_pkg;
   typedef enum logic [1:0] {
      K_NONE  = 2'd0,
      K_MEM   = 2'd1,
      K_BYTES = 2'd2,
      K_LANE  = 2'd3
   } imm_kind_e;

   typedef enum logic [1:0] {
      ERR_NONE = 2'd0,
      ERR_LEB  = 2'd1,
      ERR_UNK  = 2'd2
   } dec_err_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ALIGN,
      ST_OFFS,
      ST_BYTES,
      ST_LANE
   } dec_state_e;
endpackage

// File: rtl/leb_accum.sv
module leb_accum #(
   parameter int VAL_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  logic [7:0]       din,
   output logic [VAL_W-1:0] value,
   output logic             done,
   output logic             err
);
   localparam int MAXB    = (VAL_W + 6) / 7;
   localparam int TOP_BITS = VAL_W - 7 * (MAXB - 1);
   localparam int CW      = (MAXB > 1) ? $clog2(MAXB) : 1;

   if (VAL_W % 7 == 0 || VAL_W < 8) begin : g_bad_width
      $error("leb_accum: VAL_W must be at least 8 and not a multiple of 7");
   end

   logic [CW-1:0]      cnt;
   logic [VAL_W-1:0]   acc;
   logic [VAL_W+6:0]   wide;
   logic               last_pos;

   assign wide     = {{VAL_W{1'b0}}, din[6:0]} << (7 * int'(cnt));
   assign value    = acc | wide[VAL_W-1:0];
   assign last_pos = (cnt == CW'(MAXB - 1));
   assign err      = last_pos && (din[7] || (|din[6:TOP_BITS]));
   assign done     = !din[7] && !err;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         acc <= '0;
      end else if (step) begin
         if (done || err) begin
            cnt <= '0;
            acc <= '0;
         end else begin
            cnt <= cnt + 1'b1;
            acc <= value;
         end
      end
   end

   // R2
   leb_adv_chk: assert property (@(posedge clk) disable iff (rst)
      (step && din[7] && !err) |=> (cnt == $past(cnt) + 1'b1));

   // R8
   leb_restart_chk: assert property (@(posedge clk) disable iff (rst)
      (step && (err || !din[7])) |=> (cnt == '0));
endmodule

// File: rtl/simd_op_class.sv
module simd_op_class #(
   parameter int OPC_W = 32
) (
   input  logic [OPC_W-1:0]        opcode,
   output logic                    known,
   output simd_dec_pkg::imm_kind_e kind
);
   import simd_dec_pkg::*;

   always_comb begin
      known = 1'b1;
      kind  = K_NONE;
      if (opcode <= OPC_W'(11)) begin
         kind = K_MEM;
      end else if (opcode <= OPC_W'(13)) begin
         kind = K_BYTES;
      end else if (opcode <= OPC_W'(20)) begin
         kind = K_NONE;
      end else if (opcode <= OPC_W'(34)) begin
         kind = K_LANE;
      end else if (opcode <= OPC_W'(82)) begin
         kind = K_NONE;
      end else if (opcode > OPC_W'(255)) begin
         known = 1'b0;
      end else begin
         case (opcode[7:0]) inside
            [8'd96:8'd102], [8'd107:8'd115], [8'd118:8'd121], 8'd123,
            [8'd128:8'd147], [8'd149:8'd153], 8'd155,
            [8'd160:8'd164], [8'd167:8'd174], 8'd177, [8'd181:8'd185],
            8'd193, [8'd203:8'd206], 8'd209, 8'd213,
            8'd224, 8'd225, [8'd227:8'd233],
            8'd236, 8'd237, [8'd239:8'd245],
            [8'd248:8'd251]: known = 1'b1;
            default:         known = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/imm_gather.sv
module imm_gather #(
   parameter int NBYTES = 16
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  clr,
   input  logic                  wr,
   input  logic [IDX_W-1:0]      idx,
   input  logic [7:0]            din,
   output logic [8*NBYTES-1:0]   dout
);
   localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   for (genvar g = 0; g < NBYTES; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst || clr) begin
            dout[8*g +: 8] <= '0;
         end else if (wr && idx == IDX_W'(g)) begin
            dout[8*g +: 8] <= din;
         end
      end
   end
endmodule

// File: rtl/simd_stream_decoder.sv
module simd_stream_decoder #(
   parameter int         OPC_W     = 32,
   parameter int         IMM_BYTES = 16,
   parameter logic [7:0] PREFIX    = 8'hFD
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [7:0]             in_byte,
   output logic                   in_ready,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic                   out_is_vec,
   output logic [OPC_W-1:0]       out_opcode,
   output logic [1:0]             out_kind,
   output logic [1:0]             out_err,
   output logic [OPC_W-1:0]       out_align,
   output logic [OPC_W-1:0]       out_offset,
   output logic [7:0]             out_lane,
   output logic [8*IMM_BYTES-1:0] out_imm
);
   import simd_dec_pkg::*;

   localparam int IDX_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMM_BYTES - 1);

   if (OPC_W < 9) begin : g_bad_opc
      $error("simd_stream_decoder: OPC_W must hold the defined opcodes");
   end

   dec_state_e       state;
   logic             fire, leb_step, leb_done, leb_err, cls_known;
   logic [OPC_W-1:0] leb_val;
   imm_kind_e        cls_kind, r_kind;
   dec_err_e         r_err;
   logic [IDX_W-1:0] bcnt;

   assign in_ready = !out_valid;
   assign fire     = in_valid && in_ready;
   assign leb_step = fire && (state == ST_OPC || state == ST_ALIGN || state == ST_OFFS);
   assign out_kind = r_kind;
   assign out_err  = r_err;

   leb_accum #(.VAL_W(OPC_W)) leb_i (
      .clk(clk), .rst(rst), .step(leb_step), .din(in_byte),
      .value(leb_val), .done(leb_done), .err(leb_err)
   );

   simd_op_class #(.OPC_W(OPC_W)) cls_i (
      .opcode(leb_val), .known(cls_known), .kind(cls_kind)
   );

   imm_gather #(.NBYTES(IMM_BYTES)) gat_i (
      .clk(clk), .rst(rst),
      .clr(fire && state == ST_IDLE),
      .wr(fire && state == ST_BYTES),
      .idx(bcnt), .din(in_byte), .dout(out_imm)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= ST_IDLE;
         out_valid  <= 1'b0;
         out_is_vec <= 1'b0;
         out_opcode <= '0;
         out_align  <= '0;
         out_offset <= '0;
         out_lane   <= '0;
         r_kind     <= K_NONE;
         r_err      <= ERR_NONE;
         bcnt       <= '0;
      end else begin
         if (out_valid && out_ready) out_valid <= 1'b0;
         if (fire) begin
            case (state)
               ST_IDLE: begin
                  out_align  <= '0;
                  out_offset <= '0;
                  out_lane   <= '0;
                  r_kind     <= K_NONE;
                  r_err      <= ERR_NONE;
                  bcnt       <= '0;
                  if (in_byte == PREFIX) begin
                     out_is_vec <= 1'b1;
                     out_opcode <= '0;
                     state      <= ST_OPC;
                  end else begin
                     out_is_vec <= 1'b0;
                     out_opcode <= OPC_W'(in_byte);
                     out_valid  <= 1'b1;
                  end
               end
               ST_OPC: begin
                  if (leb_err) begin
                     r_err     <= ERR_LEB;
                     out_valid <= 1'b1;
                     state     <= ST_IDLE;
                  end else if (leb_done) begin
                     out_opcode <= leb_val;
                     if (!cls_known) begin
                        r_err     <= ERR_UNK;
                        out_valid <= 1'b1;
                        state     <= ST_IDLE;
                     end else begin
                        r_kind <= cls_kind;
                        case (cls_kind)
                           K_MEM:   state <= ST_ALIGN;
                           K_BYTES: state <= ST_BYTES;
                           K_LANE:  state <= ST_LANE;
                           default: begin
                              out_valid <= 1'b1;
                              state     <= ST_IDLE;
                           end
                        endcase
                     end
                  end
               end
               ST_ALIGN: begin
                  if (leb_err) begin
                     r_err     <= ERR_LEB;
                     out_valid <= 1'b1;
                     state     <= ST_IDLE;
                  end else if (leb_done) begin
                     out_align <= leb_val;
                     state     <= ST_OFFS;
                  end
               end
               ST_OFFS: begin
                  if (leb_err) begin
                     r_err     <= ERR_LEB;
                     out_valid <= 1'b1;
                     state     <= ST_IDLE;
                  end else if (leb_done) begin
                     out_offset <= leb_val;
                     out_valid  <= 1'b1;
                     state      <= ST_IDLE;
                  end
               end
               ST_BYTES: begin
                  bcnt <= bcnt + 1'b1;
                  if (bcnt == LAST_IDX) begin
                     out_valid <= 1'b1;
                     state     <= ST_IDLE;
                  end
               end
               ST_LANE: begin
                  out_lane  <= in_byte;
                  out_valid <= 1'b1;
                  state     <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) && $stable(out_imm)
         && $stable(out_offset) && $stable(out_align) && $stable(out_lane) && $stable(out_err)));

   // R1
   plain_rec_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_is_vec) |-> (out_err == ERR_NONE && out_kind == K_NONE
         && out_opcode < OPC_W'(256)));

   // R9
   unknown_noimm_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_err == ERR_UNK) |-> (out_kind == K_NONE && out_imm == '0
         && out_lane == '0 && out_offset == '0 && out_align == '0));

   // R3
   mem_range_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_kind == K_MEM && out_err == ERR_NONE) |-> (out_opcode <= OPC_W'(11)));

   // R6
   lane_range_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_kind == K_LANE) |-> (out_opcode >= OPC_W'(21) && out_opcode <= OPC_W'(34)));
endmodule

// File: tb/simd_stream_decoder_tb_top.sv
module simd_stream_decoder_tb_top;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [7:0]   in_byte = 8'h00;
   logic         in_ready;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic         out_is_vec;
   logic [31:0]  out_opcode, out_align, out_offset;
   logic [1:0]   out_kind, out_err;
   logic [7:0]   out_lane;
   logic [127:0] out_imm;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic         c_vec;
   logic [31:0]  c_op, c_align, c_off;
   logic [1:0]   c_kind, c_err;
   logic [7:0]   c_lane;
   logic [127:0] c_imm;

   always #2 clk = ~clk;

   simd_stream_decoder dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_is_vec(out_is_vec),
      .out_opcode(out_opcode), .out_kind(out_kind), .out_err(out_err),
      .out_align(out_align), .out_offset(out_offset), .out_lane(out_lane), .out_imm(out_imm)
   );

   task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic send(logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic get_rec();
      @(negedge clk);
      while (!out_valid) @(negedge clk);
      c_vec = out_is_vec; c_op = out_opcode; c_kind = out_kind; c_err = out_err;
      c_align = out_align; c_off = out_offset; c_lane = out_lane; c_imm = out_imm;
      out_ready = 1'b1;
      @(posedge clk);
      #1 out_ready = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R11", "out_valid after reset", 128'(out_valid), 128'd0);
      chk("R11", "in_ready after reset", 128'(in_ready), 128'd1);
   endtask

   task automatic t_plain();
      send(8'h41); get_rec();
      chk("R1", "plain is_vec", 128'(c_vec), 128'd0);
      chk("R1", "plain byte", 128'(c_op), 128'h41);
      chk("R1", "plain kind/err", 128'({c_kind, c_err}), 128'd0);
   endtask

   task automatic t_noimm();
      send(8'hFD); send(8'h52); get_rec();
      chk("R7", "op 82", 128'({c_op, c_kind, c_err}), 128'({32'd82, 2'd0, 2'd0}));
      send(8'hFD); send(8'hE0); send(8'h01); get_rec();
      chk("R2", "two-byte op 224", 128'(c_op), 128'd224);
      chk("R7", "op 224 kind/err", 128'({c_kind, c_err}), 128'd0);
      send(8'hFD); send(8'hFB); send(8'h01); get_rec();
      chk("R7", "op 251", 128'({c_op, c_kind, c_err}), 128'({32'd251, 2'd0, 2'd0}));
      send(8'hFD); send(8'h8E); send(8'h80); send(8'h80); send(8'h80); send(8'h00); get_rec();
      chk("R2", "padded five-byte op 14", 128'({c_op, c_kind, c_err}), 128'({32'd14, 2'd0, 2'd0}));
   endtask

   task automatic t_memarg();
      send(8'hFD); send(8'h00); send(8'h04); send(8'hE5); send(8'h8E); send(8'h26); get_rec();
      chk("R3", "load kind", 128'({c_kind, c_err}), 128'({2'd1, 2'd0}));
      chk("R3", "align", 128'(c_align), 128'd4);
      chk("R3", "offset", 128'(c_off), 128'd624485);
      send(8'hFD); send(8'h0B); send(8'h02); send(8'h00); get_rec();
      chk("R3", "store op/align/off", 128'({c_op, c_align, c_off}), 128'({32'd11, 32'd2, 32'd0}));
   endtask

   task automatic t_const();
      logic [127:0] exp = '0;
      send(8'hFD); send(8'h0C);
      for (int k = 0; k < 16; k++) begin
         send(8'(k * 17 + 3));
         exp[8*k +: 8] = 8'(k * 17 + 3);
      end
      get_rec();
      chk("R4", "const kind", 128'({c_op, c_kind, c_err}), 128'({32'd12, 2'd2, 2'd0}));
      chk("R4", "const value", c_imm, exp);
   endtask

   task automatic t_shuffle();
      send(8'hFD); send(8'h0D);
      for (int k = 0; k < 16; k++) send(8'(15 - k));
      get_rec();
      chk("R5", "shuffle kind", 128'({c_op, c_kind}), 128'({32'd13, 2'd2}));
      for (int k = 0; k < 16; k++)
         chk("R5", $sformatf("lane %0d", k), 128'(c_imm[8*k +: 8]), 128'(15 - k));
   endtask

   task automatic t_lane();
      send(8'hFD); send(8'h15); send(8'h07); get_rec();
      chk("R6", "lane op21", 128'({c_op, c_kind, c_lane}), 128'({32'd21, 2'd3, 8'd7}));
      send(8'hFD); send(8'h22); send(8'h01); get_rec();
      chk("R6", "lane op34", 128'({c_op, c_kind, c_lane, c_err}), 128'({32'd34, 2'd3, 8'd1, 2'd0}));
   endtask

   task automatic t_leb_err();
      send(8'hFD);
      for (int k = 0; k < 5; k++) send(8'h80);
      get_rec();
      chk("R8", "fifth byte continues", 128'(c_err), 128'd1);
      send(8'h41); get_rec();
      chk("R8", "resync plain", 128'({c_vec, c_op}), 128'({1'b0, 32'h41}));
      send(8'hFD); send(8'h80); send(8'h80); send(8'h80); send(8'h80); send(8'h10); get_rec();
      chk("R8", "fifth byte high bits", 128'(c_err), 128'd1);
      send(8'hFD); send(8'h52); get_rec();
      chk("R8", "resync vector", 128'({c_op, c_err}), 128'({32'd82, 2'd0}));
   endtask

   task automatic t_unknown();
      send(8'hFD); send(8'h53); get_rec();
      chk("R9", "op 83", 128'({c_op, c_err, c_kind}), 128'({32'd83, 2'd2, 2'd0}));
      chk("R9", "op 83 imm", c_imm | 128'(c_lane) | 128'(c_off), 128'd0);
      send(8'hFD); send(8'hC3); send(8'h01); get_rec();
      chk("R9", "op 195", 128'({c_op, c_err}), 128'({32'd195, 2'd2}));
      send(8'hFD); send(8'h15); send(8'h05); get_rec();
      chk("R9", "next after unknown", 128'({c_op, c_lane, c_err}), 128'({32'd21, 8'd5, 2'd0}));
   endtask

   task automatic t_hold();
      send(8'hFD); send(8'h16); send(8'h09);
      repeat (4) @(negedge clk);
      chk("R10", "valid held", 128'(out_valid), 128'd1);
      chk("R10", "in_ready low", 128'(in_ready), 128'd0);
      chk("R10", "lane held", 128'({out_opcode, out_lane}), 128'({32'd22, 8'd9}));
      get_rec();
      @(negedge clk);
      chk("R10", "valid drops after take", 128'(out_valid), 128'd0);
   endtask

   task automatic t_reset_mid();
      send(8'hFD); send(8'h0C); send(8'hAA); send(8'hBB);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R11", "no record after reset", 128'(out_valid), 128'd0);
      send(8'h42); get_rec();
      chk("R11", "idle after reset", 128'({c_vec, c_op}), 128'({1'b0, 32'h42}));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_plain();
      t_noimm();
      t_memarg();
      t_const();
      t_shuffle();
      t_lane();
      t_leb_err();
      t_unknown();
      t_hold();
      t_reset_mid();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule